// File: doc/BRIEF.md
# Gigabit PCS Management Register File

This block is the software-visible control and status register bank of a gigabit PCS that runs either 1000BASE-X or SGMII. A simple register bus presents a word address with a read or write strobe. Writes take effect at the clock edge. Read data comes back one cycle later with a valid strobe. The block holds the configuration the PCS needs: the auto-negotiation enable, the advertised ability word, the 21-bit link timer and the interface mode. It exposes these directly as output ports.

Two command bits are write-one and self-clearing. One starts a soft reset and the other restarts auto-negotiation. Each is a small two-state machine, `CMD_IDLE` and `CMD_PEND`:
- `CMD_IDLE` goes to `CMD_PEND` when software writes 1. This transition emits a one-cycle request pulse to the controlled engine.
- `CMD_PEND` goes back to `CMD_IDLE` when that engine acknowledges.

The page-received event flag is a second two-state machine, `PG_EMPTY` and `PG_FULL`:
- `PG_EMPTY` goes to `PG_FULL` on a partner page strobe, which also captures the partner ability word.
- `PG_FULL` goes to `PG_EMPTY` when software reads the expansion register, unless a new page arrives in that same cycle.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: After reset, these registers read as follows: control (0x00) 0x0000, advertised ability (0x04) 0x01A0, link timer low (0x12) 0x8A00, link timer high (0x13) 0x0009, interface mode (0x14) 0x0000, scratch (0x10) 0x0000. The link_timer output is 0x98A00.
- R2: Writing 1 to control bit 15 sets that bit. It also raises soft_reset_req for exactly the one cycle after the write. The bit reads 1 until reset_done is seen, then reads 0. Other register contents are unchanged by the soft reset.
- R3: Writing 1 to control bit 9 sets that bit and pulses an_restart_req for one cycle. The bit clears when an_restart_ack is seen. Control bit 12 is a plain read/write bit that drives an_enable.
- R4: Writing 0 to a command bit (15 or 9) changes nothing. Writing 1 while the same command is pending produces no second request pulse.
- R5: Status (0x01) is read-only: bit 5 equals an_complete, bit 3 is always 1, bit 2 equals link_up, and all other bits are 0.
- R6: In the advertised ability register (0x04), only bits [13:12], [8:7] and 5 are writable; the other bits read 0. The register value appears on adv_ability.
- R7: A partner_page_valid pulse captures partner_ability into address 0x05 and sets bit 1 of 0x06. A read of 0x06 returns the flag and then clears it, unless a new pulse arrives in the same cycle, in which case the flag stays 1. Bit 0 of 0x06 equals partner_an_able.
- R8: The link timer is 21 bits: address 0x12 holds bits [15:0] and address 0x13 holds bits [20:16]. The full value appears on link_timer.
- R9: Interface mode (0x14) holds bit 0 for SGMII select, bit 1 for use-negotiated-abilities and bits [3:2] for manual speed. These drive sgmii_en, sgmii_use_an and sgmii_speed.
- R10: bus_rvalid rises exactly one cycle after a read strobe. Addresses 0x07, 0x08 and all unmapped addresses read 0 and ignore writes. Addresses 0x02/0x03 return the high and low halves of the PHY_ID parameter, 0x11 returns REV, and 0x10 is fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| soft_reset_req | output | 1 | One-cycle soft reset request |
| reset_done | input | 1 | Soft reset completed |
| an_restart_req | output | 1 | One-cycle auto-negotiation restart request |
| an_restart_ack | input | 1 | Restart has been started |
| an_complete | input | 1 | Auto-negotiation finished |
| link_up | input | 1 | Link established |
| partner_ability | input | 16 | Received partner ability word |
| partner_page_valid | input | 1 | Partner ability word is new |
| partner_an_able | input | 1 | Partner supports auto-negotiation |
| an_enable | output | 1 | Auto-negotiation enable |
| adv_ability | output | 16 | Advertised ability word |
| link_timer | output | 21 | Link timer in 16 ns units |
| sgmii_en | output | 1 | SGMII mode select |
| sgmii_use_an | output | 1 | Use negotiated SGMII abilities |
| sgmii_speed | output | 2 | Manual SGMII speed |

## Verification
The bench sets PHY_ID to 0x0123_4567 and REV to 0x00A5, which differ from the defaults. This shows that addresses 0x02, 0x03 and 0x11 follow the parameters rather than constants, and that the two identifier halves are not swapped. ADDR_W stays at 5, so every location from 0x00 to 0x1F can be reached, including reserved holes such as 0x0C and 0x1F. The same-cycle page event and clear-on-read collision is driven explicitly, as are acknowledges that arrive while a command is idle.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;
    localparam int DATA_W  = 16;
    localparam int TIMER_W = 21;

    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_STAT    = 8'h01;
    localparam logic [7:0] A_ID_HI   = 8'h02;
    localparam logic [7:0] A_ID_LO   = 8'h03;
    localparam logic [7:0] A_ADV     = 8'h04;
    localparam logic [7:0] A_PARTNER = 8'h05;
    localparam logic [7:0] A_EXPAN   = 8'h06;
    localparam logic [7:0] A_SCRATCH = 8'h10;
    localparam logic [7:0] A_REV     = 8'h11;
    localparam logic [7:0] A_TMR_LO  = 8'h12;
    localparam logic [7:0] A_TMR_HI  = 8'h13;
    localparam logic [7:0] A_IFMODE  = 8'h14;

    localparam logic [15:0] ADV_MASK  = 16'h31A0;
    localparam logic [15:0] ADV_RESET = 16'h01A0;
    localparam logic [15:0] TMR_LO_RESET = 16'h8A00;
    localparam logic [4:0]  TMR_HI_RESET = 5'h09;

    localparam int BIT_SRST   = 15;
    localparam int BIT_AN_EN  = 12;
    localparam int BIT_AN_RST = 9;

    typedef enum logic {CMD_IDLE, CMD_PEND} cmd_state_t;
    typedef enum logic {PG_EMPTY, PG_FULL} page_state_t;
endpackage

// File: rtl/pcs_cmd_bit.sv
module pcs_cmd_bit
    import pcs_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic pending_o,
    output logic req_o
);
    cmd_state_t state_q, state_d;
    logic       req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (set_i) state_d = CMD_PEND;
            CMD_PEND: if (ack_i) state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= (state_q == CMD_IDLE) && set_i;
    end

    assign pending_o = (state_q == CMD_PEND);
    assign req_o     = req_q;

    // R4: a request never lasts two cycles
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R2: entering the pending state is announced by a request
    p_req_on_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> req_o);
    // R3: pending is released only by an acknowledge
    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ack_i) |=> pending_o);
endmodule

// File: rtl/pcs_page_flag.sv
module pcs_page_flag
    import pcs_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    page_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_EMPTY: if (set_i) state_d = PG_FULL;
            PG_FULL:  if (clr_i && !set_i) state_d = PG_EMPTY;
        endcase
    end

    assign flag_o = (state_q == PG_FULL);

    // R7: a new page always leaves the flag set, even against a clearing read
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R7: without a read the flag never drops
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int          ADDR_W = 5,
    parameter logic [31:0] PHY_ID = 32'h0000_0000,
    parameter logic [15:0] REV    = 16'h0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [15:0]        bus_wdata,
    input  logic               bus_rd,
    output logic [15:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               soft_reset_req,
    input  logic               reset_done,
    output logic               an_restart_req,
    input  logic               an_restart_ack,
    input  logic               an_complete,
    input  logic               link_up,
    input  logic [15:0]        partner_ability,
    input  logic               partner_page_valid,
    input  logic               partner_an_able,
    output logic               an_enable,
    output logic [15:0]        adv_ability,
    output logic [20:0]        link_timer,
    output logic               sgmii_en,
    output logic               sgmii_use_an,
    output logic [1:0]         sgmii_speed
);
    localparam int AW8 = (ADDR_W < 8) ? ADDR_W : 8;

    logic [7:0] addr8;
    assign addr8 = 8'(bus_addr[AW8-1:0]) | ((ADDR_W > 8) && (|(bus_addr >> AW8)) ? 8'hFF : 8'h00);

    function automatic logic hit(input logic [7:0] a, input logic [7:0] target);
        return a == target;
    endfunction

    logic wr_ctrl, wr_adv, wr_scr, wr_tlo, wr_thi, wr_ifm;
    assign wr_ctrl = bus_wr && hit(addr8, A_CTRL);
    assign wr_adv  = bus_wr && hit(addr8, A_ADV);
    assign wr_scr  = bus_wr && hit(addr8, A_SCRATCH);
    assign wr_tlo  = bus_wr && hit(addr8, A_TMR_LO);
    assign wr_thi  = bus_wr && hit(addr8, A_TMR_HI);
    assign wr_ifm  = bus_wr && hit(addr8, A_IFMODE);

    logic        srst_pend, anr_pend, page_flag;
    logic        an_en_q;
    logic [15:0] adv_q, partner_q, scratch_q, tmr_lo_q;
    logic [4:0]  tmr_hi_q;
    logic [3:0]  ifm_q;

    pcs_cmd_bit u_srst (
        .clk(clk), .rst_n(rst_n),
        .set_i(wr_ctrl && bus_wdata[BIT_SRST]),
        .ack_i(reset_done),
        .pending_o(srst_pend), .req_o(soft_reset_req)
    );

    pcs_cmd_bit u_anrst (
        .clk(clk), .rst_n(rst_n),
        .set_i(wr_ctrl && bus_wdata[BIT_AN_RST]),
        .ack_i(an_restart_ack),
        .pending_o(anr_pend), .req_o(an_restart_req)
    );

    pcs_page_flag u_page (
        .clk(clk), .rst_n(rst_n),
        .set_i(partner_page_valid),
        .clr_i(bus_rd && hit(addr8, A_EXPAN)),
        .flag_o(page_flag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            an_en_q   <= 1'b0;
            adv_q     <= ADV_RESET;
            partner_q <= '0;
            scratch_q <= '0;
            tmr_lo_q  <= TMR_LO_RESET;
            tmr_hi_q  <= TMR_HI_RESET;
            ifm_q     <= '0;
        end else begin
            if (wr_ctrl) an_en_q   <= bus_wdata[BIT_AN_EN];
            if (wr_adv)  adv_q     <= bus_wdata & ADV_MASK;
            if (wr_scr)  scratch_q <= bus_wdata;
            if (wr_tlo)  tmr_lo_q  <= bus_wdata;
            if (wr_thi)  tmr_hi_q  <= bus_wdata[4:0];
            if (wr_ifm)  ifm_q     <= bus_wdata[3:0];
            if (partner_page_valid) partner_q <= partner_ability;
        end
    end

    logic [15:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        unique case (addr8)
            A_CTRL:    begin
                           rd_mux[BIT_SRST]   = srst_pend;
                           rd_mux[BIT_AN_EN]  = an_en_q;
                           rd_mux[BIT_AN_RST] = anr_pend;
                       end
            A_STAT:    begin
                           rd_mux[5] = an_complete;
                           rd_mux[3] = 1'b1;
                           rd_mux[2] = link_up;
                       end
            A_ID_HI:   rd_mux = PHY_ID[31:16];
            A_ID_LO:   rd_mux = PHY_ID[15:0];
            A_ADV:     rd_mux = adv_q;
            A_PARTNER: rd_mux = partner_q;
            A_EXPAN:   rd_mux = {14'd0, page_flag, partner_an_able};
            A_SCRATCH: rd_mux = scratch_q;
            A_REV:     rd_mux = REV;
            A_TMR_LO:  rd_mux = tmr_lo_q;
            A_TMR_HI:  rd_mux = {11'd0, tmr_hi_q};
            A_IFMODE:  rd_mux = {12'd0, ifm_q};
            default:   rd_mux = '0;
        endcase
    end

    logic [15:0] rdata_q;
    logic        rvalid_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_rvalid   = rvalid_q;
    assign an_enable    = an_en_q;
    assign adv_ability  = adv_q;
    assign link_timer   = {tmr_hi_q, tmr_lo_q};
    assign sgmii_en     = ifm_q[0];
    assign sgmii_use_an = ifm_q[1];
    assign sgmii_speed  = ifm_q[3:2];

    // R10: read valid follows the read strobe by exactly one cycle
    p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_no_spurious_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R5: status always reports the ability bit
    p_ability_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr8 == A_STAT) |=> bus_rdata[3]);
    // R10: next page locations read zero
    p_next_page_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (addr8 == 8'h07 || addr8 == 8'h08)) |=> (bus_rdata == 16'h0));
    // R6: reserved ability bits never appear
    p_adv_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ability & ~ADV_MASK) == 16'h0);
endmodule

// File: tb/tb_pcs_mgmt_regs.sv
module tb_pcs_mgmt_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TB_ID  = 32'h0123_4567;
    localparam logic [15:0] TB_REV = 16'h00A5;

    logic        clk = 0, rst_n = 0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        bus_rvalid, soft_reset_req, an_restart_req;
    logic        reset_done = 0, an_restart_ack = 0, an_complete = 0, link_up = 0;
    logic [15:0] partner_ability = '0;
    logic        partner_page_valid = 0, partner_an_able = 0;
    logic        an_enable, sgmii_en, sgmii_use_an;
    logic [15:0] adv_ability;
    logic [20:0] link_timer;
    logic [1:0]  sgmii_speed;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_mgmt_regs #(.ADDR_W(5), .PHY_ID(TB_ID), .REV(TB_REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .soft_reset_req(soft_reset_req),
        .reset_done(reset_done), .an_restart_req(an_restart_req),
        .an_restart_ack(an_restart_ack), .an_complete(an_complete),
        .link_up(link_up), .partner_ability(partner_ability),
        .partner_page_valid(partner_page_valid), .partner_an_able(partner_an_able),
        .an_enable(an_enable), .adv_ability(adv_ability), .link_timer(link_timer),
        .sgmii_en(sgmii_en), .sgmii_use_an(sgmii_use_an), .sgmii_speed(sgmii_speed)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // all drives happen at negedge; the cycle's posedge follows
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1;
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
        chk("R10 rvalid", 32'(bus_rvalid), 1);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R10 rvalid idle", 32'(bus_rvalid), 0);
        rd(5'h00, v); chk("R1 control", 32'(v), 32'h0000);
        rd(5'h04, v); chk("R1 adv", 32'(v), 32'h01A0);
        rd(5'h12, v); chk("R1 timer lo", 32'(v), 32'h8A00);
        rd(5'h13, v); chk("R1 timer hi", 32'(v), 32'h0009);
        rd(5'h14, v); chk("R1 ifmode", 32'(v), 32'h0000);
        rd(5'h10, v); chk("R1 scratch", 32'(v), 32'h0000);
        chk("R1 link_timer port", 32'(link_timer), 32'h98A00);
        chk("R1 req idle", {30'd0, soft_reset_req, an_restart_req}, 0);
    endtask

    task automatic t_soft_reset();
        logic [15:0] v;
        wr(5'h10, 16'hBEEF);
        wr(5'h00, 16'h8000);
        chk("R2 reset pulse", 32'(soft_reset_req), 1);
        idle(1);
        chk("R2 pulse one cycle", 32'(soft_reset_req), 0);
        rd(5'h00, v); chk("R2 pending bit", 32'(v[15]), 1);
        reset_done = 1; @(negedge clk); reset_done = 0;
        rd(5'h00, v); chk("R2 cleared", 32'(v[15]), 0);
        rd(5'h10, v); chk("R2 contents kept", 32'(v), 32'hBEEF);
        rd(5'h04, v); chk("R2 adv kept", 32'(v), 32'h01A0);
    endtask

    task automatic t_restart_an();
        logic [15:0] v;
        wr(5'h00, 16'h1200);
        chk("R3 restart pulse", 32'(an_restart_req), 1);
        chk("R3 an_enable", 32'(an_enable), 1);
        idle(1);
        chk("R3 pulse one cycle", 32'(an_restart_req), 0);
        rd(5'h00, v); chk("R3 control", 32'(v), 32'h1200);
        an_restart_ack = 1; @(negedge clk); an_restart_ack = 0;
        rd(5'h00, v); chk("R3 restart cleared", 32'(v), 32'h1000);
        wr(5'h00, 16'h0000);
        chk("R3 an_enable off", 32'(an_enable), 0);
    endtask

    task automatic t_cmd_rules();
        logic [15:0] v;
        wr(5'h00, 16'h0000);
        chk("R4 zero write no pulse", {30'd0, soft_reset_req, an_restart_req}, 0);
        rd(5'h00, v); chk("R4 zero write no pend", 32'(v), 0);
        wr(5'h00, 16'h8000);
        idle(1);
        wr(5'h00, 16'h8000);
        chk("R4 repeat no second pulse", 32'(soft_reset_req), 0);
        rd(5'h00, v); chk("R4 still pending", 32'(v[15]), 1);
        wr(5'h00, 16'h0000);
        rd(5'h00, v); chk("R4 zero keeps pending", 32'(v[15]), 1);
        reset_done = 1; @(negedge clk); reset_done = 0;
        rd(5'h00, v); chk("R4 single request retired", 32'(v[15]), 0);
        an_restart_ack = 1; @(negedge clk); an_restart_ack = 0;
        rd(5'h00, v); chk("R4 idle ack harmless", 32'(v), 0);
    endtask

    task automatic t_status();
        logic [15:0] v;
        an_complete = 0; link_up = 0;
        rd(5'h01, v); chk("R5 status none", 32'(v), 32'h0008);
        an_complete = 1; link_up = 1;
        rd(5'h01, v); chk("R5 status all", 32'(v), 32'h002C);
        an_complete = 1; link_up = 0;
        rd(5'h01, v); chk("R5 status an only", 32'(v), 32'h0028);
        wr(5'h01, 16'hFFFF);
        an_complete = 0;
        rd(5'h01, v); chk("R5 status read-only", 32'(v), 32'h0008);
    endtask

    task automatic t_adv();
        logic [15:0] v;
        wr(5'h04, 16'hFFFF);
        rd(5'h04, v); chk("R6 adv mask", 32'(v), 32'h31A0);
        chk("R6 adv port", 32'(adv_ability), 32'h31A0);
        wr(5'h04, 16'h1000);
        rd(5'h04, v); chk("R6 adv write", 32'(v), 32'h1000);
    endtask

    task automatic t_page();
        logic [15:0] v;
        partner_an_able = 1;
        rd(5'h06, v); chk("R7 expansion empty", 32'(v), 32'h0001);
        partner_ability = 16'hC1A0; partner_page_valid = 1;
        @(negedge clk); partner_page_valid = 0; partner_ability = 16'h0;
        rd(5'h05, v); chk("R7 partner captured", 32'(v), 32'hC1A0);
        rd(5'h06, v); chk("R7 page set", 32'(v), 32'h0003);
        rd(5'h06, v); chk("R7 cleared by read", 32'(v), 32'h0001);
        partner_an_able = 0;
        partner_page_valid = 1; @(negedge clk); partner_page_valid = 0;
        partner_page_valid = 1;
        rd(5'h06, v);
        partner_page_valid = 0;
        chk("R7 collision read value", 32'(v), 32'h0002);
        rd(5'h06, v); chk("R7 collision kept", 32'(v), 32'h0002);
        rd(5'h06, v); chk("R7 then cleared", 32'(v), 32'h0000);
    endtask

    task automatic t_timer();
        logic [15:0] v;
        wr(5'h12, 16'h1234);
        wr(5'h13, 16'hFFFF);
        rd(5'h13, v); chk("R8 timer hi width", 32'(v), 32'h001F);
        rd(5'h12, v); chk("R8 timer lo", 32'(v), 32'h1234);
        chk("R8 timer port", 32'(link_timer), 32'h1F1234);
    endtask

    task automatic t_ifmode();
        logic [15:0] v;
        wr(5'h14, 16'hFFFB);
        rd(5'h14, v); chk("R9 ifmode", 32'(v), 32'h000B);
        chk("R9 ports", {27'd0, sgmii_speed, sgmii_use_an, sgmii_en}, 32'h0B);
        wr(5'h14, 16'h0004);
        chk("R9 ports speed only", {27'd0, sgmii_speed, sgmii_use_an, sgmii_en}, 32'h04);
    endtask

    task automatic t_misc();
        logic [15:0] v;
        rd(5'h02, v); chk("R10 id hi", 32'(v), 32'h0123);
        rd(5'h03, v); chk("R10 id lo", 32'(v), 32'h4567);
        rd(5'h11, v); chk("R10 rev", 32'(v), 32'h00A5);
        wr(5'h10, 16'h5A5A);
        rd(5'h10, v); chk("R10 scratch", 32'(v), 32'h5A5A);
        wr(5'h07, 16'hFFFF); wr(5'h08, 16'hFFFF); wr(5'h0C, 16'hFFFF); wr(5'h1F, 16'hFFFF);
        rd(5'h07, v); chk("R10 next page tx", 32'(v), 0);
        rd(5'h08, v); chk("R10 next page rx", 32'(v), 0);
        rd(5'h0C, v); chk("R10 hole 0C", 32'(v), 0);
        rd(5'h1F, v); chk("R10 hole 1F", 32'(v), 0);
        rd(5'h10, v); chk("R10 scratch untouched", 32'(v), 32'h5A5A);
        idle(1);
        chk("R10 rvalid drops", 32'(bus_rvalid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_soft_reset();
        t_restart_an();
        t_cmd_rules();
        t_status();
        t_adv();
        t_page();
        t_timer();
        t_ifmode();
        t_misc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule